// File: doc/BRIEF.md
# Decimal Accumulator Processor

This block is a compact multi-cycle processor built around one accumulator and a bank of one hundred decimal cells ("mailboxes") that hold both the program and its data. Every word stores a value from 000 to 999. The leading decimal digit of an instruction is its operation and the two trailing digits name a mailbox. Words are carried internally as binary integers, and the digits are split off by constant division.

Before the core starts, a loader fills the memory through a preload write port while reset is held. After reset is released, the core runs from mailbox 00 until it reaches a halt instruction. Each instruction takes a fetch cycle and an execute cycle, plus any stall cycles spent on I/O. Values are read in through a valid/ready input port and sent out through a valid/ready output port. The `halted` pin reports that execution has stopped, and the `neg_flag` pin shows the borrow state that the conditional branch tests.

Top module: `dac_core`

## Requirements
- R1: While reset is low, `halted`, `in_ready`, `out_valid` and `neg_flag` are 0. On release, execution starts at mailbox 00 with the accumulator at 000.
- R2: Opcode digit 1 (1xx) adds mailbox xx to the accumulator modulo 1000 and clears the negative flag. The mailbox is left unchanged.
- R3: Opcode digit 2 (2xx) subtracts mailbox xx from the accumulator modulo 1000. It sets the negative flag exactly when the true difference is below zero and clears it otherwise, so an equal operand gives 000 with the flag clear.
- R4: Opcode digit 3 (3xx) writes the accumulator into mailbox xx and leaves the accumulator unchanged.
- R5: Opcode digit 5 (5xx) copies mailbox xx into the accumulator and clears the negative flag.
- R6: Opcode digit 6 (6xx) makes mailbox xx the next instruction unconditionally.
- R7: Opcode digit 7 (7xx) jumps to xx only when the accumulator is 000. Otherwise it continues with the next mailbox.
- R8: Opcode digit 8 (8xx) jumps to xx only when the negative flag is clear.
- R9: Word 901 stalls with `in_ready` high until `in_valid` is seen. It then replaces the accumulator with `in_data` and clears the negative flag. `in_ready` is low at all other times.
- R10: Word 902 raises `out_valid` with `out_data` equal to the accumulator. Both are held until one cycle with `out_ready` high, which makes exactly one transfer. The accumulator is not changed.
- R11: An opcode digit of 0 (0xx, including 000) halts the core. `halted` then stays high until reset, and neither port handshakes again.
- R12: Opcode digit 4, and any 9xx word other than 901 and 902, only advance the program counter. The program counter wraps from 99 to 00.
- R13: While `load_en` is high, `load_data` is written into mailbox `load_addr` on the clock edge. The core then executes whatever words were loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Preload write strobe |
| load_addr | input | ADDR_W (7) | Preload mailbox index |
| load_data | input | WORD_W (10) | Preload word, 0..999 |
| in_valid | input | 1 | Input value offered |
| in_data | input | WORD_W (10) | Input value |
| in_ready | output | 1 | Core is waiting on a 901 |
| out_valid | output | 1 | Output value offered |
| out_data | output | WORD_W (10) | Output value |
| out_ready | input | 1 | Receiver takes the output value |
| halted | output | 1 | Core has stopped |
| neg_flag | output | 1 | Borrow from the most recent subtract |

## Verification
Each opcode is run inside a short program whose output stream would differ if the opcode misbehaved. Add is checked across the 999→000 wrap. Subtract is checked with a smaller operand, a larger operand and an equal operand, which separates correct borrow handling from a plain unsigned wrap. Each branch kind is run both taken and not taken. The accumulator value or the flag state is chosen so that a wrongly taken or wrongly skipped jump changes what is emitted. The I/O program is run with delayed `in_valid` and with back-pressured `out_ready`. This shows stalling and single transfers apart from free-running handshakes. A no-operation sweep that runs through mailbox 99 shows that the program counter wraps and that unused codes cause no port traffic.

// File: rtl/dac_pkg.sv
package dac_pkg;

   // integer power used to derive word and address spans from the digit count
   function automatic int unsigned dac_pow(input int unsigned base, input int unsigned expo);
      int unsigned r;
      r = 1;
      for (int unsigned i = 0; i < expo; i++) r = r * base;
      return r;
   endfunction

   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_EXEC  = 2'd1,
      ST_OUT   = 2'd2,
      ST_HALT  = 2'd3
   } dac_state_e;

   typedef enum logic [3:0] {
      K_HALT  = 4'd0,
      K_ADD   = 4'd1,
      K_SUB   = 4'd2,
      K_STORE = 4'd3,
      K_LOAD  = 4'd4,
      K_JMP   = 4'd5,
      K_JZ    = 4'd6,
      K_JNN   = 4'd7,
      K_IN    = 4'd8,
      K_OUT   = 4'd9,
      K_NOP   = 4'd10
   } dac_kind_e;

endpackage

// File: rtl/dac_alu.sv
module dac_alu #(
   parameter int WORD_W   = 10,
   parameter int WORD_MOD = 1000
) (
   input  logic [WORD_W-1:0] acc,
   input  logic [WORD_W-1:0] opd,
   input  logic              do_sub,
   output logic [WORD_W-1:0] result,
   output logic              borrow
);
   localparam logic [WORD_W:0] MOD_V = (WORD_W+1)'(WORD_MOD);

   logic [WORD_W:0] ext_a;
   logic [WORD_W:0] ext_b;
   logic [WORD_W:0] raw;

   assign ext_a = {1'b0, acc};
   assign ext_b = {1'b0, opd};

   always_comb begin
      raw    = '0;
      borrow = 1'b0;
      if (do_sub) begin
         if (ext_a >= ext_b) begin
            raw = ext_a - ext_b;
         end else begin
            raw    = ext_a + MOD_V - ext_b;
            borrow = 1'b1;
         end
      end else begin
         raw = ext_a + ext_b;
         if (raw >= MOD_V) raw = raw - MOD_V;
      end
      result = raw[WORD_W-1:0];
   end
endmodule

// File: rtl/dac_decode.sv
module dac_decode
   import dac_pkg::*;
#(
   parameter int WORD_W    = 10,
   parameter int ADDR_W    = 7,
   parameter int ADDR_SPAN = 100
) (
   input  logic [WORD_W-1:0] word,
   output dac_kind_e         kind,
   output logic [ADDR_W-1:0] addr
);
   logic [3:0] op_digit;

   assign op_digit = 4'(word / ADDR_SPAN);
   assign addr     = ADDR_W'(word % ADDR_SPAN);

   always_comb begin
      unique case (op_digit)
         4'd0:    kind = K_HALT;
         4'd1:    kind = K_ADD;
         4'd2:    kind = K_SUB;
         4'd3:    kind = K_STORE;
         4'd5:    kind = K_LOAD;
         4'd6:    kind = K_JMP;
         4'd7:    kind = K_JZ;
         4'd8:    kind = K_JNN;
         4'd9: begin
            if (addr == ADDR_W'(1))      kind = K_IN;
            else if (addr == ADDR_W'(2)) kind = K_OUT;
            else                         kind = K_NOP;
         end
         default: kind = K_NOP;
      endcase
   end
endmodule

// File: rtl/dac_mem.sv
module dac_mem #(
   parameter int WORD_W = 10,
   parameter int ADDR_W = 7,
   parameter int DEPTH  = 100
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [WORD_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == ADDR_W'(i))) cell_q <= wr_data;
      end
      assign cells[i] = cell_q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_data = cells[i];
      end
   end
endmodule

// File: rtl/dac_core.sv
module dac_core
   import dac_pkg::*;
#(
   parameter int DIGIT_BASE  = 10,
   parameter int WORD_DIGITS = 3,
   parameter int WORD_MOD    = int'(dac_pkg::dac_pow(DIGIT_BASE, WORD_DIGITS)),
   parameter int ADDR_SPAN   = int'(dac_pkg::dac_pow(DIGIT_BASE, WORD_DIGITS - 1)),
   parameter int WORD_W      = $clog2(WORD_MOD),
   parameter int ADDR_W      = $clog2(ADDR_SPAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [WORD_W-1:0] load_data,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   input  logic              out_ready,
   output logic              halted,
   output logic              neg_flag
);
   localparam logic [ADDR_W-1:0] PC_LAST = ADDR_W'(ADDR_SPAN - 1);

   if (DIGIT_BASE != 10) begin : g_bad_base
      $error("dac_core: the opcode map needs decimal digits");
   end
   if (WORD_DIGITS < 3) begin : g_bad_digits
      $error("dac_core: a word needs an opcode digit and two address digits");
   end
   if ((1 << WORD_W) < WORD_MOD || (1 << ADDR_W) < ADDR_SPAN) begin : g_bad_width
      $error("dac_core: word or address width too narrow");
   end

   dac_state_e        state_q;
   logic [ADDR_W-1:0] pc_q;
   logic [WORD_W-1:0] ir_q;
   logic [WORD_W-1:0] acc_q;
   logic              neg_q;
   logic              out_valid_q;
   logic [WORD_W-1:0] out_data_q;

   dac_kind_e         kind;
   logic [ADDR_W-1:0] op_addr;
   logic [ADDR_W-1:0] pc_seq;
   logic [ADDR_W-1:0] rd_addr;
   logic [WORD_W-1:0] rd_data;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [WORD_W-1:0] mem_wdata;
   logic [WORD_W-1:0] alu_y;
   logic              alu_borrow;
   logic [WORD_W-1:0] in_val;

   dac_decode #(
      .WORD_W   (WORD_W),
      .ADDR_W   (ADDR_W),
      .ADDR_SPAN(ADDR_SPAN)
   ) u_decode (
      .word(ir_q),
      .kind(kind),
      .addr(op_addr)
   );

   assign rd_addr   = (state_q == ST_FETCH) ? pc_q : op_addr;
   assign mem_we    = load_en || (state_q == ST_EXEC && kind == K_STORE);
   assign mem_waddr = load_en ? load_addr : op_addr;
   assign mem_wdata = load_en ? load_data : acc_q;

   dac_mem #(
      .WORD_W(WORD_W),
      .ADDR_W(ADDR_W),
      .DEPTH (ADDR_SPAN)
   ) u_mem (
      .clk    (clk),
      .wr_en  (mem_we),
      .wr_addr(mem_waddr),
      .wr_data(mem_wdata),
      .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

   dac_alu #(
      .WORD_W  (WORD_W),
      .WORD_MOD(WORD_MOD)
   ) u_alu (
      .acc   (acc_q),
      .opd   (rd_data),
      .do_sub(kind == K_SUB),
      .result(alu_y),
      .borrow(alu_borrow)
   );

   assign pc_seq = (pc_q == PC_LAST) ? '0 : pc_q + ADDR_W'(1);
   assign in_val = WORD_W'(in_data % WORD_MOD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_FETCH;
         pc_q        <= '0;
         ir_q        <= '0;
         acc_q       <= '0;
         neg_q       <= 1'b0;
         out_valid_q <= 1'b0;
         out_data_q  <= '0;
      end else begin
         unique case (state_q)
            ST_FETCH: begin
               ir_q    <= rd_data;
               pc_q    <= pc_seq;
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               state_q <= ST_FETCH;
               unique case (kind)
                  K_ADD: begin
                     acc_q <= alu_y;
                     neg_q <= 1'b0;
                  end
                  K_SUB: begin
                     acc_q <= alu_y;
                     neg_q <= alu_borrow;
                  end
                  K_LOAD: begin
                     acc_q <= rd_data;
                     neg_q <= 1'b0;
                  end
                  K_JMP: pc_q <= op_addr;
                  K_JZ: begin
                     if (acc_q == '0) pc_q <= op_addr;
                  end
                  K_JNN: begin
                     if (!neg_q) pc_q <= op_addr;
                  end
                  K_IN: begin
                     if (in_valid) begin
                        acc_q <= in_val;
                        neg_q <= 1'b0;
                     end else begin
                        state_q <= ST_EXEC;
                     end
                  end
                  K_OUT: begin
                     out_valid_q <= 1'b1;
                     out_data_q  <= acc_q;
                     state_q     <= ST_OUT;
                  end
                  K_HALT: state_q <= ST_HALT;
                  default: ;
               endcase
            end
            ST_OUT: begin
               if (out_ready) begin
                  out_valid_q <= 1'b0;
                  state_q     <= ST_FETCH;
               end
            end
            default: state_q <= ST_HALT;
         endcase
      end
   end

   assign in_ready  = (state_q == ST_EXEC) && (kind == K_IN);
   assign out_valid = out_valid_q;
   assign out_data  = out_data_q;
   assign halted    = (state_q == ST_HALT);
   assign neg_flag  = neg_q;
endmodule

// File: rtl/dac_core_chk.sv
module dac_core_chk #(
   parameter int WORD_W    = 10,
   parameter int ADDR_W    = 7,
   parameter int WORD_MOD  = 1000,
   parameter int ADDR_SPAN = 100
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_data,
   input logic              halted,
   input logic              neg_flag,
   input logic [WORD_W-1:0] acc,
   input logic [ADDR_W-1:0] pc
);
   localparam logic [WORD_W-1:0] MOD_V  = WORD_W'(WORD_MOD);
   localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(ADDR_SPAN);

   assert_reset_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pc == '0 && acc == '0 && !halted && !out_valid && !neg_flag));

   assert_acc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc < MOD_V);

   assert_in_clears_neg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !neg_flag);

   assert_in_ready_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!out_valid && !halted));

   assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_out_matches_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data == acc));

   assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!in_ready && !out_valid));

   assert_pc_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pc < SPAN_V);
endmodule

bind dac_core dac_core_chk #(
   .WORD_W   (WORD_W),
   .ADDR_W   (ADDR_W),
   .WORD_MOD (WORD_MOD),
   .ADDR_SPAN(ADDR_SPAN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data),
   .halted   (halted),
   .neg_flag (neg_flag),
   .acc      (acc_q),
   .pc       (pc_q)
);

// File: tb/dac_core_bench.sv
module dac_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WW = 10;
   localparam int AW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_en = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [WW-1:0] load_data = '0;
   logic          in_valid = 1'b0;
   logic [WW-1:0] in_data = '0;
   logic          in_ready;
   logic          out_valid;
   logic [WW-1:0] out_data;
   logic          out_ready = 1'b0;
   logic          halted;
   logic          neg_flag;

   int n_checks = 0;
   int n_fail   = 0;

   int prog    [0:99];
   int in_buf  [0:7];
   int exp_out [0:7];
   int got_out [0:15];
   int in_n, exp_n, got_n, ready_cycles;
   bit run_done;

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_core u_dac_core (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .halted(halted), .neg_flag(neg_flag)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 100; i++) prog[i] = 0;
      in_n = 0;
      exp_n = 0;
   endtask

   // preload under reset (R13), run to halt with optional input delay and output back-pressure
   task automatic run_prog(input int in_gap, input bit bp);
      int in_idx;
      int gap;
      rst_n = 1'b0;
      in_valid = 1'b0;
      out_ready = 1'b0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         load_en = 1'b1;
         load_addr = AW'(i);
         load_data = WW'(prog[i]);
      end
      @(negedge clk);
      load_en = 1'b0;
      rst_n = 1'b1;
      got_n = 0;
      ready_cycles = 0;
      in_idx = 0;
      gap = 0;
      run_done = 1'b0;
      for (int cyc = 0; cyc < 4000; cyc++) begin
         @(negedge clk);
         if (halted) begin
            run_done = 1'b1;
            break;
         end
         out_ready = !bp || (cyc % 3 == 2);
         #1;
         in_valid = 1'b0;
         if (in_ready) begin
            ready_cycles++;
            if (in_idx < in_n && gap >= in_gap) begin
               in_valid = 1'b1;
               in_data = WW'(in_buf[in_idx]);
               in_idx++;
               gap = 0;
            end else begin
               gap++;
            end
         end
         if (out_valid && out_ready) begin
            if (got_n < 16) got_out[got_n] = int'(out_data);
            got_n++;
         end
      end
      in_valid = 1'b0;
      out_ready = 1'b0;
   endtask

   task automatic check_outputs(input string req);
      chk(req, "halt reached", int'(run_done), 1);
      chk(req, "output count", got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) chk(req, "output value", got_out[i], exp_out[i]);
   endtask

   task automatic t_reset();
      clear_prog();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "halted in reset", int'(halted), 0);
      chk("R1", "in_ready in reset", int'(in_ready), 0);
      chk("R1", "out_valid in reset", int'(out_valid), 0);
      chk("R1", "neg_flag in reset", int'(neg_flag), 0);
      prog[0] = 902;
      exp_out[0] = 0; exp_n = 1;
      run_prog(0, 1'b0);
      check_outputs("R1");
   endtask

   task automatic t_add();
      clear_prog();
      prog[0] = 593; prog[1] = 294; prog[2] = 190; prog[3] = 191;
      prog[4] = 902; prog[5] = 591; prog[6] = 902;
      prog[90] = 600; prog[91] = 450; prog[93] = 3; prog[94] = 7;
      exp_out[0] = 46; exp_out[1] = 450; exp_n = 2;
      run_prog(0, 1'b0);
      check_outputs("R2");
      chk("R2", "add clears negative flag", int'(neg_flag), 0);
   endtask

   task automatic t_sub();
      clear_prog();
      prog[0] = 590; prog[1] = 291; prog[2] = 902; prog[3] = 291; prog[4] = 902;
      prog[90] = 600; prog[91] = 450;
      exp_out[0] = 150; exp_out[1] = 700; exp_n = 2;
      run_prog(0, 1'b0);
      check_outputs("R3");
      chk("R3", "underflow sets negative flag", int'(neg_flag), 1);
      clear_prog();
      prog[0] = 593; prog[1] = 294; prog[2] = 591; prog[3] = 291; prog[4] = 902;
      prog[91] = 450; prog[93] = 3; prog[94] = 7;
      exp_out[0] = 0; exp_n = 1;
      run_prog(0, 1'b0);
      check_outputs("R3");
      chk("R3", "equal operand leaves flag clear", int'(neg_flag), 0);
   endtask

   task automatic t_store_load();
      clear_prog();
      prog[0] = 590; prog[1] = 395; prog[2] = 191; prog[3] = 902;
      prog[4] = 595; prog[5] = 902; prog[6] = 593; prog[7] = 294; prog[8] = 590;
      prog[90] = 600; prog[91] = 450; prog[93] = 3; prog[94] = 7;
      exp_out[0] = 50; exp_out[1] = 600; exp_n = 2;
      run_prog(0, 1'b0);
      check_outputs("R4");
      chk("R5", "load clears negative flag", int'(neg_flag), 0);
   endtask

   task automatic t_branch();
      // R6 unconditional jump skips an output
      clear_prog();
      prog[0] = 590; prog[1] = 604; prog[2] = 902; prog[4] = 902; prog[90] = 600;
      exp_out[0] = 600; exp_n = 1;
      run_prog(0, 1'b0);
      check_outputs("R6");
      // R7 taken with a zero accumulator
      clear_prog();
      prog[0] = 596; prog[1] = 704; prog[2] = 902; prog[4] = 590; prog[5] = 902; prog[90] = 600;
      exp_out[0] = 600; exp_n = 1;
      run_prog(0, 1'b0);
      check_outputs("R7");
      // R7 not taken with a nonzero accumulator
      clear_prog();
      prog[0] = 590; prog[1] = 704; prog[2] = 902; prog[4] = 591; prog[5] = 902;
      prog[90] = 600; prog[91] = 450;
      exp_out[0] = 600; exp_n = 1;
      run_prog(0, 1'b0);
      check_outputs("R7");
      // R8 skipped after a borrow, taken after a load
      clear_prog();
      prog[0] = 593; prog[1] = 294; prog[2] = 806; prog[3] = 902; prog[4] = 590;
      prog[5] = 807; prog[7] = 902; prog[90] = 600; prog[93] = 3; prog[94] = 7;
      exp_out[0] = 996; exp_out[1] = 600; exp_n = 2;
      run_prog(0, 1'b0);
      check_outputs("R8");
   endtask

   task automatic t_io();
      clear_prog();
      prog[0] = 593; prog[1] = 294; prog[2] = 901; prog[3] = 902; prog[4] = 901;
      prog[5] = 190; prog[6] = 902; prog[90] = 600; prog[93] = 3; prog[94] = 7;
      in_buf[0] = 123; in_buf[1] = 950; in_n = 2;
      exp_out[0] = 123; exp_out[1] = 550; exp_n = 2;
      run_prog(6, 1'b1);
      check_outputs("R10");
      chk("R9", "cycles spent waiting with in_ready", ready_cycles, 2 * 7);
      chk("R9", "input clears negative flag", int'(neg_flag), 0);
   endtask

   task automatic t_halt();
      int bad;
      clear_prog();
      prog[0] = 0; prog[1] = 902; prog[2] = 901;
      exp_n = 0;
      run_prog(0, 1'b0);
      check_outputs("R11");
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         out_ready = 1'b1;
         #1;
         if (!halted || in_ready || out_valid) bad++;
      end
      in_valid = 1'b0;
      out_ready = 1'b0;
      chk("R11", "cycles with activity after halt", bad, 0);
   endtask

   task automatic t_nop_wrap();
      clear_prog();
      prog[0] = 597; prog[1] = 703; prog[2] = 0; prog[3] = 400; prog[4] = 903;
      prog[5] = 999; prog[6] = 950; prog[7] = 590; prog[8] = 397; prog[9] = 698;
      prog[98] = 902; prog[99] = 423; prog[90] = 600;
      exp_out[0] = 600; exp_n = 1;
      run_prog(0, 1'b0);
      check_outputs("R12");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_add();
      t_sub();
      t_store_load();
      t_branch();
      t_io();
      t_halt();
      t_nop_wrap();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule